// File: doc/BRIEF.md
# Cacheability Region Priority Resolver

This block decides, for every memory access, which of four cache modes applies: copyback, write-through, inhibited-precise or inhibited-imprecise. It also reports whether the address lies inside one of the on-chip RAM windows. The decision comes from three tiers of region registers, searched in a fixed order. On-chip RAM windows are searched first, then the access-control regions that serve the access's class (instruction or data), and finally a default-mode register. The result is registered and appears one cycle after the access is presented.

Software programs the region registers through a single-cycle write port that selects a register by index. Each access-control region compares the top address byte against a base byte under a don't-care mask. Even-numbered access-control regions serve instruction fetches and odd-numbered ones serve data accesses. Within a class, the lower-numbered region wins. The result also names the register that produced it, so the memory pipeline can trace a mode back to its origin.

Top module: `cache_region_resolver`

## Requirements
- R1: An on-chip RAM window i is hit when its enable bit (write-data bit 0) is 1 and address bits 31:16 equal its base (write-data bits 31:16). A hit sets `res_ram`=1, `res_mode`=2'b10 and `res_src`=1+i. Window 0 wins over window 1, and any window hit wins over every access-control region and the default.
- R2: Access-control region k matches when its enable bit (write-data bit 15) is 1 and, for every bit where the mask (write-data bits 23:16) is 0, address bits 31:24 equal the base (write-data bits 31:24). A mask bit of 1 makes that address bit a don't-care. The mode is taken from write-data bits 1:0.
- R3: An instruction access (`acc_instr`=1) considers only regions 0 and 2, and region 0 wins over region 2. The source code is 3 for region 0 and 5 for region 2.
- R4: A data access (`acc_instr`=0) considers only regions 1 and 3, and region 1 wins over region 3. The source code is 4 for region 1 and 6 for region 3.
- R5: An access that hits no RAM window and no eligible region takes its mode from the default register (write-data bits 1:0), with `res_src`=0 and `res_ram`=0.
- R6: The mode encoding is 00 copyback, 01 write-through, 10 inhibited-precise and 11 inhibited-imprecise. `res_inhibit` is 1 for both inhibited modes and 0 for the other two.
- R7: `res_valid` is 1 exactly in the cycle after a cycle with `acc_valid`=1. The result fields in that cycle belong to that access.
- R8: A write with `cfg_we`=1 loads the register chosen by `cfg_sel`: 0 and 1 select RAM windows 0 and 1, 2 to 5 select regions 0 to 3, and 6 selects the default. The new value takes effect for accesses presented in later cycles. An access in the same cycle as the write still sees the old value.
- R9: After reset every RAM window and region is disabled, the default mode is 10, and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index for the write |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| res_valid | output | 1 | Result valid |
| res_mode | output | 2 | Selected cache mode |
| res_inhibit | output | 1 | Selected mode is one of the inhibited modes |
| res_ram | output | 1 | Address lies in an on-chip RAM window |
| res_src | output | 3 | Register that produced the result (0 = default) |

## Verification
The same address is sent once as an instruction fetch and once as a data access. This shows that the even and odd regions are kept apart by class. Overlapping regions and windows are enabled one at a time, then disabled in turn, so that each priority tier wins and then yields to the one below it. Addresses are placed just inside and just outside the don't-care span of a mask, which separates masked bits from compared ones. A write and an access in the same cycle, followed by back-to-back accesses with idle gaps between them, separate the timing of the register update from the one-cycle result latency.

// File: rtl/crr_pkg.sv
package crr_pkg;

    typedef enum logic [1:0] {
        CM_COPYBACK      = 2'b00,
        CM_WRTHRU        = 2'b01,
        CM_INH_PRECISE   = 2'b10,
        CM_INH_IMPRECISE = 2'b11
    } cmode_e;

    // access-control region fields, as laid out on the write port
    localparam int ACR_BASE_MSB = 31;
    localparam int ACR_MASK_MSB = 23;
    localparam int ACR_EN_BIT   = 15;
    localparam int FIELD_W      = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
        logic               en;
        cmode_e             mode;
    } acr_t;

endpackage

// File: rtl/crr_cfg_regs.sv
module crr_cfg_regs
    import crr_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          RAM_LSB       = 16,
    parameter int          N_RAM         = 2,
    parameter int          N_ACR         = 4,
    parameter logic [1:0]  RST_DFLT_MODE = 2'b10,
    localparam int         RB_W          = ADDR_W - RAM_LSB,
    localparam int         SEL_W         = $clog2(N_RAM + N_ACR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [RB_W-1:0]   ram_base [N_RAM],
    output logic              ram_en   [N_RAM],
    output acr_t              acr      [N_ACR],
    output cmode_e            dflt_mode
);

    localparam int DFLT_IDX = N_RAM + N_ACR;

    for (genvar i = 0; i < N_RAM; i++) begin : g_ram
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ram_base[i] <= '0;
                ram_en[i]   <= 1'b0;
            end else if (cfg_we && cfg_sel == SEL_W'(i)) begin
                ram_base[i] <= cfg_wdata[ADDR_W-1 -: RB_W];
                ram_en[i]   <= cfg_wdata[0];
            end
        end
    end

    for (genvar k = 0; k < N_ACR; k++) begin : g_acr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acr[k] <= '{base: '0, mask: '0, en: 1'b0, mode: CM_COPYBACK};
            end else if (cfg_we && cfg_sel == SEL_W'(N_RAM + k)) begin
                acr[k].base <= cfg_wdata[ACR_BASE_MSB -: FIELD_W];
                acr[k].mask <= cfg_wdata[ACR_MASK_MSB -: FIELD_W];
                acr[k].en   <= cfg_wdata[ACR_EN_BIT];
                acr[k].mode <= cmode_e'(cfg_wdata[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_mode <= cmode_e'(RST_DFLT_MODE);
        end else if (cfg_we && cfg_sel == SEL_W'(DFLT_IDX)) begin
            dflt_mode <= cmode_e'(cfg_wdata[1:0]);
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata[ACR_EN_BIT-1:2];

endmodule

// File: rtl/crr_acr_match.sv
module crr_acr_match
    import crr_pkg::*;
(
    input  acr_t               region,
    input  logic [FIELD_W-1:0] addr_hi,
    output logic               hit
);

    logic [FIELD_W-1:0] diff;

    always_comb begin
        diff = (addr_hi ^ region.base) & ~region.mask;
        hit  = region.en && (diff == '0);
    end

endmodule

// File: rtl/crr_ram_match.sv
module crr_ram_match #(
    parameter int RB_W = 16
) (
    input  logic [RB_W-1:0] base,
    input  logic            en,
    input  logic [RB_W-1:0] addr_hi,
    output logic            hit
);

    always_comb begin
        hit = en && (addr_hi == base);
    end

endmodule

// File: rtl/crr_prio_pick.sv
module crr_prio_pick
    import crr_pkg::*;
#(
    parameter int  N_RAM = 2,
    parameter int  N_ACR = 4,
    localparam int SRC_W = $clog2(N_RAM + N_ACR + 1)
) (
    input  logic [N_RAM-1:0] ram_hit,
    input  logic [N_ACR-1:0] acr_hit,
    input  cmode_e           acr_mode [N_ACR],
    input  cmode_e           dflt_mode,
    input  logic             is_instr,
    output cmode_e           pick_mode,
    output logic             pick_ram,
    output logic [SRC_W-1:0] pick_src
);

    always_comb begin
        pick_mode = dflt_mode;
        pick_ram  = 1'b0;
        pick_src  = '0;
        // lowest index written last so it wins; even regions serve fetches
        for (int k = N_ACR - 1; k >= 0; k--) begin
            if (acr_hit[k] && (((k % 2) == 0) == is_instr)) begin
                pick_mode = acr_mode[k];
                pick_src  = SRC_W'(1 + N_RAM + k);
            end
        end
        for (int i = N_RAM - 1; i >= 0; i--) begin
            if (ram_hit[i]) begin
                pick_mode = CM_INH_PRECISE;
                pick_ram  = 1'b1;
                pick_src  = SRC_W'(1 + i);
            end
        end
    end

endmodule

// File: rtl/cache_region_resolver.sv
module cache_region_resolver
    import crr_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          RAM_LSB       = 16,
    parameter int          N_RAM         = 2,
    parameter int          N_ACR         = 4,
    parameter logic [1:0]  RST_DFLT_MODE = 2'b10,
    localparam int         RB_W          = ADDR_W - RAM_LSB,
    localparam int         SEL_W         = $clog2(N_RAM + N_ACR + 1),
    localparam int         SRC_W         = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_instr,
    output logic              res_valid,
    output logic [1:0]        res_mode,
    output logic              res_inhibit,
    output logic              res_ram,
    output logic [SRC_W-1:0]  res_src
);

    logic [RB_W-1:0] ram_base [N_RAM];
    logic            ram_en   [N_RAM];
    acr_t            acr      [N_ACR];
    cmode_e          dflt_mode;
    cmode_e          acr_mode [N_ACR];
    logic [N_RAM-1:0] ram_hit;
    logic [N_ACR-1:0] acr_hit;
    cmode_e           pick_mode;
    logic             pick_ram;
    logic [SRC_W-1:0] pick_src;

    crr_cfg_regs #(
        .ADDR_W(ADDR_W), .RAM_LSB(RAM_LSB), .N_RAM(N_RAM),
        .N_ACR(N_ACR), .RST_DFLT_MODE(RST_DFLT_MODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ram_base(ram_base), .ram_en(ram_en),
        .acr(acr), .dflt_mode(dflt_mode)
    );

    for (genvar i = 0; i < N_RAM; i++) begin : g_ram_cmp
        crr_ram_match #(.RB_W(RB_W)) u_ram (
            .base(ram_base[i]), .en(ram_en[i]),
            .addr_hi(acc_addr[ADDR_W-1 -: RB_W]), .hit(ram_hit[i])
        );
    end

    for (genvar k = 0; k < N_ACR; k++) begin : g_acr_cmp
        crr_acr_match u_acr (
            .region(acr[k]), .addr_hi(acc_addr[ADDR_W-1 -: FIELD_W]),
            .hit(acr_hit[k])
        );
        assign acr_mode[k] = acr[k].mode;
    end

    crr_prio_pick #(.N_RAM(N_RAM), .N_ACR(N_ACR)) u_pick (
        .ram_hit(ram_hit), .acr_hit(acr_hit), .acr_mode(acr_mode),
        .dflt_mode(dflt_mode), .is_instr(acc_instr),
        .pick_mode(pick_mode), .pick_ram(pick_ram), .pick_src(pick_src)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_mode    <= 2'b00;
            res_inhibit <= 1'b0;
            res_ram     <= 1'b0;
            res_src     <= '0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_mode    <= pick_mode;
                res_inhibit <= (pick_mode == CM_INH_PRECISE) ||
                               (pick_mode == CM_INH_IMPRECISE);
                res_ram     <= pick_ram;
                res_src     <= pick_src;
            end
        end
    end

    logic unused_addr;
    assign unused_addr = ^acc_addr[RAM_LSB-1:0];

endmodule

// File: rtl/crr_checks.sv
module crr_checks #(
    parameter int N_RAM = 2,
    parameter int SRC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_instr,
    input logic             res_valid,
    input logic [1:0]       res_mode,
    input logic             res_inhibit,
    input logic             res_ram,
    input logic [SRC_W-1:0] res_src
);

    localparam logic [SRC_W-1:0] FIRST_ACR = SRC_W'(1 + N_RAM);

    logic [SRC_W-1:0] acr_off;
    logic             src_is_ram;
    assign acr_off    = res_src - FIRST_ACR;
    assign src_is_ram = (res_src != '0) && (res_src < FIRST_ACR);

    AST_RAM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ram) |-> (res_mode == 2'b10 && res_inhibit)); // R1
    AST_RAM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_ram == src_is_ram)); // R1
    AST_INSTR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src >= FIRST_ACR && $past(acc_instr)) |-> (acr_off[0] == 1'b0)); // R3
    AST_DATA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src >= FIRST_ACR && !$past(acc_instr)) |-> (acr_off[0] == 1'b1)); // R4
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R7
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid); // R7

endmodule

bind cache_region_resolver crr_checks #(.N_RAM(N_RAM), .SRC_W(SRC_W)) u_crr_checks (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_instr(acc_instr),
    .res_valid(res_valid), .res_mode(res_mode), .res_inhibit(res_inhibit),
    .res_ram(res_ram), .res_src(res_src)
);

// File: tb/cache_region_resolver_test.sv
`timescale 1ns/1ps
module cache_region_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_instr = 1'b0;
    logic        res_valid;
    logic [1:0]  res_mode;
    logic        res_inhibit;
    logic        res_ram;
    logic [2:0]  res_src;

    always #2 clk = ~clk;

    cache_region_resolver uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_instr(acc_instr), .res_valid(res_valid), .res_mode(res_mode),
        .res_inhibit(res_inhibit), .res_ram(res_ram), .res_src(res_src)
    );

    typedef struct {
        logic [1:0] mode;
        logic       ram;
        logic [2:0] src;
        int         due;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // bench copy of the programmed registers
    logic [15:0] m_rbase [2];
    logic        m_ren   [2];
    logic [7:0]  m_abase [4];
    logic [7:0]  m_amask [4];
    logic        m_aen   [4];
    logic [1:0]  m_amode [4];
    logic [1:0]  m_dflt;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] acr_word(logic [7:0] b, logic [7:0] m, logic en, logic [1:0] md);
        return {b, m, en, 13'b0, md};
    endfunction

    function automatic logic [31:0] ram_word(logic [15:0] b, logic en);
        return {b, 15'b0, en};
    endfunction

    function automatic exp_t predict(logic [31:0] a, logic instr, string tag);
        exp_t e;
        e.mode = m_dflt; e.ram = 1'b0; e.src = 3'd0; e.tag = tag; e.due = 0;
        for (int k = 3; k >= 0; k--) begin
            if (m_aen[k] && (((k % 2) == 0) == instr) &&
                (((a[31:24] ^ m_abase[k]) & ~m_amask[k]) == 8'h00)) begin
                e.mode = m_amode[k]; e.src = 3'(3 + k);
            end
        end
        for (int i = 1; i >= 0; i--) begin
            if (m_ren[i] && a[31:16] == m_rbase[i]) begin
                e.mode = 2'b10; e.ram = 1'b1; e.src = 3'(1 + i);
            end
        end
        return e;
    endfunction

    task automatic mirror(logic [2:0] sel, logic [31:0] d);
        if (sel < 3'd2) begin
            m_rbase[sel] = d[31:16]; m_ren[sel] = d[0];
        end else if (sel < 3'd6) begin
            m_abase[sel-2] = d[31:24]; m_amask[sel-2] = d[23:16];
            m_aen[sel-2] = d[15]; m_amode[sel-2] = d[1:0];
        end else if (sel == 3'd6) begin
            m_dflt = d[1:0];
        end
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; acc_valid = 1'b0;
        mirror(sel, d);
    endtask

    task automatic send(logic [31:0] a, logic instr, string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b1; acc_addr = a; acc_instr = instr;
        e = predict(a, instr, tag);
        e.due = cyc + 1;
        q.push_back(e);
    endtask

    // access and register write in the same cycle: prediction uses old values
    task automatic send_with_write(logic [31:0] a, logic instr, logic [2:0] sel,
                                   logic [31:0] d, string tag);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        acc_valid = 1'b1; acc_addr = a; acc_instr = instr;
        e = predict(a, instr, tag);
        e.due = cyc + 1;
        q.push_back(e);
        mirror(sel, d);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            cfg_we = 1'b0; acc_valid = 1'b0;
        end
    endtask

    // monitor: compare each result against the queued prediction
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R7: unexpected result src=%0d, expected no result", res_src);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.due != cyc || res_mode != e.mode || res_ram != e.ram ||
                        res_src != e.src || res_inhibit != e.mode[1]) begin
                        fails++;
                        $display("FAIL %s: cyc=%0d mode=%b ram=%b src=%0d inh=%b, expected cyc=%0d mode=%b ram=%b src=%0d inh=%b",
                                 e.tag, cyc, res_mode, res_ram, res_src, res_inhibit,
                                 e.due, e.mode, e.ram, e.src, e.mode[1]);
                    end
                end
            end else if (q.size() != 0 && q[0].due <= cyc) begin
                checks++;
                fails++;
                $display("FAIL R7: no result at cyc=%0d, expected one for %s", cyc, q[0].tag);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_rbase[i] = '0; m_ren[i] = 1'b0; end
        for (int k = 0; k < 4; k++) begin
            m_abase[k] = '0; m_amask[k] = '0; m_aen[k] = 1'b0; m_amode[k] = '0;
        end
        m_dflt = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_src !== 3'd0) begin
            fails++;
            $display("FAIL R9: reset valid=%b src=%0d, expected valid=0 src=0", res_valid, res_src);
        end
        // R9: reset default mode is inhibited-precise
        send(32'h1234_5678, 1'b0, "R9");
        idle(2);
        // R5 R8: reprogram default to write-through
        cfg_write(3'd6, 32'h0000_0001);
        send(32'h1234_5678, 1'b1, "R5");
        // R2 R3: region 0, base 0x40 with low nibble don't-care, copyback
        cfg_write(3'd2, acr_word(8'h40, 8'h0F, 1'b1, 2'b00));
        send(32'h4312_0000, 1'b1, "R2");
        send(32'h5012_0000, 1'b1, "R2");
        send(32'h4312_0000, 1'b0, "R4");
        // R3: region 2 matches everything, imprecise; region 0 still wins inside its span
        cfg_write(3'd4, acr_word(8'h40, 8'hFF, 1'b1, 2'b11));
        send(32'h4100_0000, 1'b1, "R3");
        send(32'h9000_0000, 1'b1, "R6");
        // R4: region 1 covers 0x20..0x21 write-through, region 3 0x20 precise
        cfg_write(3'd3, acr_word(8'h20, 8'h01, 1'b1, 2'b01));
        cfg_write(3'd5, acr_word(8'h20, 8'h00, 1'b1, 2'b10));
        send(32'h2100_0000, 1'b0, "R4");
        send(32'h2000_0000, 1'b0, "R4");
        send(32'h2200_0000, 1'b0, "R5");
        send(32'h2100_0000, 1'b1, "R3");
        idle(1);
        // R2: disabling region 1 hands 0x20 to region 3
        cfg_write(3'd3, acr_word(8'h20, 8'h01, 1'b0, 2'b01));
        send(32'h2000_0000, 1'b0, "R6");
        send(32'h2100_0000, 1'b0, "R2");
        // R1: both RAM windows at 0x4000xxxx; window 0 beats window 1 and region 0
        cfg_write(3'd1, ram_word(16'h4000, 1'b1));
        cfg_write(3'd0, ram_word(16'h4000, 1'b1));
        send(32'h4000_1234, 1'b0, "R1");
        send(32'h4000_FFFF, 1'b1, "R1");
        send(32'h4001_0000, 1'b1, "R1");
        idle(3);
        cfg_write(3'd0, ram_word(16'h4000, 1'b0));
        send(32'h4000_0010, 1'b1, "R1");
        // R8: write in the same cycle as an access takes effect only afterwards
        send_with_write(32'h7700_0000, 1'b0, 3'd6, 32'h0000_0000, "R8");
        send(32'h7700_0000, 1'b0, "R8");
        send_with_write(32'h4000_0000, 1'b1, 3'd1, ram_word(16'h4000, 1'b0), "R8");
        send(32'h4000_0000, 1'b1, "R8");
        idle(4);
        if (!done) begin
            done = 1'b1;
            if (q.size() != 0) begin
                checks++;
                fails++;
                $display("FAIL R7: %0d results missing, expected 0", q.size());
            end
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R7: watchdog expired, expected run to finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule